// File: doc/BRIEF.md
# Edge-Masked Interrupt Latch Controller

The controller gathers a bank of single-bit interrupt inputs from peripherals. Each input first passes through a two-flop synchroniser. The controller then compares each synchronised value with its value one clock earlier to find rising and falling edges. Three per-source mask registers decide what happens to an edge:

- the rising mask enables rising edges for that source;
- the falling mask enables falling edges for that source;
- the priority mask sends the source's edges to a high-priority latch instead of the low-priority latch.

Each latch drives one request output to the processor. That output is high whenever any bit of its latch is set.

Neither latch can be written. A pending bit stays set until software clears every mask bit of its source. Software clears mask bits by writing ones to the mask's clear address. Each mask register has two addresses, one that sets bits and one that clears them. A pending bit therefore survives partial masking, and the request stays asserted through it.

Source k sits at bit 22+k of every mask and latch word, so ten sources fill bits 22 to 31.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every mask register and both latches read zero, and irq_lo_o and irq_hi_o are low.
- R2: Mask registers use these word addresses:
  - falling mask: set at 0, clear at 1;
  - rising mask: set at 2, clear at 3;
  - priority mask: set at 4, clear at 5.

  Ones in wdata_i set or clear the matching bits. A write of all zeros changes nothing. Both addresses of a mask read back its current value.
- R3: A rising edge on a source with its rising mask bit set latches bit 22+k.
- R4: A falling edge on a source with its falling mask bit set latches bit 22+k. An edge of the other polarity on that source is not latched.
- R5: A source with neither its rising nor its falling mask bit set never latches, whatever its priority bit.
- R6: Edges of a source whose priority bit is set go to the high-priority latch (read at address 7). Edges of other sources go to the low-priority latch (read at address 6).
- R7: Writes to addresses 6 and 7 leave both latches and both request outputs unchanged.
- R8: A latched bit holds, and its request stays high, while at least one of its source's three mask bits is still set. Further edges on that source do not change it.
- R9: A clear write that leaves all three mask bits of a source at zero clears both of that source's latch bits at that clock edge. An edge detected at the same edge is not latched.
- R10: irq_lo_o and irq_hi_o are high exactly while their latch holds a set bit.
- R11: An input change is latched at the third rising clock edge after it, and only once. A steady level sets nothing, even after its mask is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | NUM_SRC | Asynchronous interrupt inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| irq_hi_o | output | 1 | High-priority interrupt request |

## Verification
A detected edge and a mask-clear write that releases the same source can land on one clock edge. The bench provokes this by dropping a falling-enabled input. It waits exactly two clocks, so that the edge reaches the latch input at the same edge as a clear write to that source's last mask bit. It then checks that the latch bit stays at zero. The bench also times a single input change against the three-edge latency. It reads the latch two clocks after the change and expects no bit, then reads it again one clock later and expects the bit.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FE_SET  = 3'd0,
    A_FE_CLR  = 3'd1,
    A_RE_SET  = 3'd2,
    A_RE_CLR  = 3'd3,
    A_PRI_SET = 3'd4,
    A_PRI_CLR = 3'd5,
    A_LAT_LO  = 3'd6,
    A_LAT_HI  = 3'd7
  } reg_addr_e;

  localparam int unsigned NUM_MASKS = 3;
  localparam int unsigned MSK_FE  = 0;
  localparam int unsigned MSK_RE  = 1;
  localparam int unsigned MSK_PRI = 2;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned N      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= src_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;

  // an edge pulse never lasts two cycles
  assert_edge_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_o | fall_o) != '0) |=> (($past(rise_o | fall_o) & (rise_o | fall_o)) == '0));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [N-1:0] q;

  always_comb begin
    nxt_o = q;
    if (set_i) nxt_o = nxt_o | bits_i;
    if (clr_i) nxt_o = nxt_o & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt_o;
  end

  assign q_o = q;

  assert_zero_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i || clr_i) && bits_i == '0) |=> $stable(q_o));
  assert_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] rel_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  // release wins over a same-cycle edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q | set_i) & ~rel_i;
  end

  assign q_o = q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(q_o & ~rel_i) & ~q_o) == '0));
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i != '0) |=> ((q_o & $past(rel_i)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eil_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 10,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SRC_LSB     = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_src_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_lo_o,
  output logic                irq_hi_o
);
  localparam int unsigned N = NUM_SRC;

  logic [N-1:0] rise, fall, hit, wr_bits, rel;
  logic [N-1:0] lat_lo, lat_hi, rd_sel;
  logic [N-1:0] msk_q [NUM_MASKS];
  logic [N-1:0] msk_n [NUM_MASKS];
  logic [NUM_MASKS-1:0] set_stb, clr_stb;
  logic [N-1:0] fe_q, re_q, pri_q, any_n;

  assign wr_bits = wdata_i[SRC_LSB +: N];

  irq_sync_edge #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .src_i(irq_src_i), .rise_o(rise), .fall_o(fall)
  );

  // mask k: set at word 2k, clear at word 2k+1
  for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
    assign set_stb[k] = we_i && (addr_i == ADDR_W'(2*k));
    assign clr_stb[k] = we_i && (addr_i == ADDR_W'(2*k+1));
    irq_mask_bank #(.N(N)) u_bank (
      .clk_i, .rst_ni, .set_i(set_stb[k]), .clr_i(clr_stb[k]),
      .bits_i(wr_bits), .q_o(msk_q[k]), .nxt_o(msk_n[k])
    );
  end

  assign fe_q  = msk_q[MSK_FE];
  assign re_q  = msk_q[MSK_RE];
  assign pri_q = msk_q[MSK_PRI];
  assign any_n = msk_n[MSK_FE] | msk_n[MSK_RE] | msk_n[MSK_PRI];

  assign hit = (rise & re_q) | (fall & fe_q);
  assign rel = (|clr_stb) ? (wr_bits & ~any_n) : '0;

  irq_latch #(.N(N)) u_lat_lo (
    .clk_i, .rst_ni, .set_i(hit & ~pri_q), .rel_i(rel), .q_o(lat_lo)
  );
  irq_latch #(.N(N)) u_lat_hi (
    .clk_i, .rst_ni, .set_i(hit & pri_q), .rel_i(rel), .q_o(lat_hi)
  );

  assign irq_lo_o = |lat_lo;
  assign irq_hi_o = |lat_hi;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_FE_SET,  A_FE_CLR:  rd_sel = fe_q;
      A_RE_SET,  A_RE_CLR:  rd_sel = re_q;
      A_PRI_SET, A_PRI_CLR: rd_sel = pri_q;
      A_LAT_LO:             rd_sel = lat_lo;
      default:              rd_sel = lat_hi;
    endcase
    rdata_o = '0;
    rdata_o[SRC_LSB +: N] = rd_sel;
  end

  assert_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((((lat_lo | lat_hi) & ~$past(lat_lo | lat_hi)) & ~$past(fe_q | re_q)) == '0));
  assert_hi_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((lat_hi & ~$past(lat_hi)) & ~$past(pri_q)) == '0));
  assert_latch_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((lat_lo | lat_hi) & ~(fe_q | re_q | pri_q)) == '0));
  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_lo_o) || $rose(irq_hi_o)) |-> ($past(hit) != '0));
endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int N = 10;
  localparam int LSB = 22;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] src = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  function automatic logic [31:0] f(input logic [N-1:0] b);
    return {b, 22'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  // {src, expected low latch, expected high latch}, source index bits
  // masks: falling {0..3}, rising {2..5}, priority {3,5,6}
  localparam logic [29:0] VEC [6] = '{
    {10'h001, 10'h000, 10'h000},  // R4 rise on falling-only source ignored
    {10'h000, 10'h001, 10'h000},  // R4 fall latches
    {10'h0C0, 10'h001, 10'h000},  // R5 priority-only / unmasked sources
    {10'h0D4, 10'h015, 10'h000},  // R3 rising edges latch
    {10'h0FC, 10'h015, 10'h028},  // R6 priority sources to high latch
    {10'h000, 10'h015, 10'h028}   // R8 repeat edges while pending
  };

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 32'd0);
    chk("R1 irq", {30'd0, irq_lo, irq_hi}, 32'd0);

    // R2 set/clear/readback
    wr(3'd0, f(10'h00F));
    wr(3'd2, f(10'h03C));
    wr(3'd4, f(10'h068));
    rd("R2 fe", 3'd0, f(10'h00F));
    rd("R2 fe clr addr", 3'd1, f(10'h00F));
    rd("R2 re", 3'd3, f(10'h03C));
    rd("R2 pri", 3'd5, f(10'h068));
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd0);
    rd("R2 zero write", 3'd0, f(10'h00F));

    foreach (VEC[i]) begin
      src = VEC[i][29:20];
      repeat (4) @(negedge clk);
      rd("R3/R4/R5/R6/R8 lo", 3'd6, f(VEC[i][19:10]));
      rd("R3/R4/R5/R6/R8 hi", 3'd7, f(VEC[i][9:0]));
      chk("R10 irq", {30'd0, irq_lo, irq_hi}, {30'd0, |VEC[i][19:10], |VEC[i][9:0]});
    end

    // R7 latch read-only
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    wr(3'd7, 32'hFFFF_FFFF);
    rd("R7 lo", 3'd6, f(10'h015));
    rd("R7 hi", 3'd7, f(10'h028));
    chk("R7 irq", {30'd0, irq_lo, irq_hi}, 32'd3);

    // R8 partial mask holds, R9 full clear releases
    wr(3'd1, f(10'h004));
    rd("R8 partial", 3'd6, f(10'h015));
    wr(3'd3, f(10'h004));
    rd("R9 release", 3'd6, f(10'h011));

    // R9 edge in the release cycle is dropped
    src[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd("R4 rise ignored", 3'd6, f(10'h011));
    src[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr(3'd1, f(10'h002));
    repeat (3) @(negedge clk);
    rd("R9 same-cycle edge", 3'd6, f(10'h011));

    // R11 latency and single set
    wr(3'd2, f(10'h004));
    repeat (3) @(negedge clk);
    rd("R11 level ignored", 3'd6, f(10'h011));
    src[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd("R11 not yet", 3'd6, f(10'h011));
    @(negedge clk);
    rd("R11 third edge", 3'd6, f(10'h015));
    wr(3'd3, f(10'h004));
    rd("R9 release src2", 3'd6, f(10'h011));
    wr(3'd2, f(10'h004));
    repeat (4) @(negedge clk);
    rd("R11 held high", 3'd6, f(10'h011));

    // R10 outputs follow latches through final clearing
    wr(3'd3, 32'hFFFF_FFFF);
    rd("R9 re clear", 3'd6, f(10'h001));
    rd("R8 pri holds", 3'd7, f(10'h028));
    wr(3'd5, 32'hFFFF_FFFF);
    rd("R8 fe holds", 3'd7, f(10'h008));
    chk("R10 both", {30'd0, irq_lo, irq_hi}, 32'd3);
    wr(3'd1, 32'hFFFF_FFFF);
    rd("R9 all lo", 3'd6, 32'd0);
    rd("R9 all hi", 3'd7, 32'd0);
    chk("R10 none", {30'd0, irq_lo, irq_hi}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule